// File: doc/BRIEF.md
# Retirement and Hazard Event Tally Unit

This unit sits next to an in-order pipeline and keeps a running count of what the pipeline does. On every clock it may see a retiring 32-bit instruction word, a stall pulse, a flush pulse and a cycle tick. It decodes each retiring word into exactly one class (a named mnemonic, the all-zero no-op, or an unimplemented R-type or I-type encoding) and bumps that class's counter and the useful-instruction counter. Stall and flush pulses are tallied on their own counters and never add to useful work.

Software or a debug harness reads any counter through a select input and a combinational data output. Cycles and useful instructions are both exposed, so CPI can be formed outside the block. A single-cycle core retires one word per tick and gives equal counts. In a pipelined core the cycle count should equal the sum of useful instructions, stalls, flushes and four fill cycles.

When the halt input goes high, every counter freezes until the next reset, so the final values can be read at leisure. Counters are `CNT_W` bits wide and stop at all ones.

Top module: `perf_tally`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every counter is cleared to zero. After reset, reading any select value returns 0.
- R2: A retiring word equal to 0x00000000 adds one to the no-op counter (select 4) and one to the useful counter (select 1).
- R3: A nonzero retiring word with bits [31:26] equal to 0 is classed by bits [5:0] into one of these counters. The select value is in brackets: 0x20 add [18], 0x21 addu [19], 0x22 sub [20], 0x24 and [21], 0x25 or [22], 0x26 xor [23], 0x27 nor [24], 0x2A slt [25], 0x00 sll [26], 0x02 srl [27], 0x03 sra [28], 0x08 jr [29], 0x0C syscall [30].
- R4: A nonzero word with bits [31:26] equal to 0 and any other bits [5:0] value adds one to the unimplemented R-type counter [31].
- R5: A word with bits [31:26] set to one of these values goes to the counter in brackets: 0x23 lw [5], 0x2B sw [6], 0x04 beq [7], 0x05 bne [8], 0x02 j [9], 0x03 jal [10], 0x08 addi [11], 0x0C andi [12], 0x0D ori [13], 0x0E xori [14], 0x0A slti [15], 0x0F lui [16].
- R6: Any other nonzero value of bits [31:26] adds one to the unimplemented I-type counter [17].
- R7: Every accepted retire, unimplemented ones included, adds exactly one to the useful counter [1]. A cycle without `retire_vld` changes no instruction counter.
- R8: `stall_pulse` adds one to the stall counter [2] and `flush_pulse` adds one to the flush counter [3]. Neither pulse changes the useful counter. Any mix of retire, stall, flush and tick in the same cycle is counted in full.
- R9: `cycle_tick` adds one to the cycle counter [0]. With four fill ticks, plus one tick for each retire, stall and flush, the cycle count equals useful + stalls + flushes + 4.
- R10: A counter at all ones stays at all ones on further events.
- R11: In a cycle where `halt` is high, no counter changes. From then on, no counter changes until reset.
- R12: `rd_data` shows, in the same cycle, the counter whose select number is on `rd_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| retire_vld | input | 1 | A word retires this cycle |
| retire_word | input | 32 | The retiring instruction word |
| stall_pulse | input | 1 | One bubble inserted this cycle |
| flush_pulse | input | 1 | One slot squashed this cycle |
| cycle_tick | input | 1 | One core cycle elapsed |
| halt | input | 1 | Freeze all counters until reset |
| rd_sel | input | 5 | Counter select |
| rd_data | output | CNT_W | Selected counter value |

## Verification
Saturation is the hardest state to reach, because a 32-bit counter cannot be filled in any practical run. The bench therefore builds the unit with 8-bit counters and retires 300 no-ops in a row. This drives the no-op, useful and cycle counters past all ones.

The decode space is swept across all 64 function codes and all 64 major opcodes. The freeze is checked by sending events in the very cycle that halt rises, and again after it falls.

// File: rtl/perf_pkg.sv
// Package: shared counter numbering and instruction field codes for the
// retirement tally unit. The select number of each counter is its index here.
package perf_pkg;

    localparam int NUM_CNT = 32;
    localparam int SEL_W   = $clog2(NUM_CNT);

    // Counter select numbers, readable through rd_sel.
    localparam int IDX_CYC   = 0;
    localparam int IDX_USE   = 1;
    localparam int IDX_STL   = 2;
    localparam int IDX_FLS   = 3;
    localparam int IDX_NOP   = 4;
    localparam int IDX_LW    = 5;
    localparam int IDX_SW    = 6;
    localparam int IDX_BEQ   = 7;
    localparam int IDX_BNE   = 8;
    localparam int IDX_J     = 9;
    localparam int IDX_JAL   = 10;
    localparam int IDX_ADDI  = 11;
    localparam int IDX_ANDI  = 12;
    localparam int IDX_ORI   = 13;
    localparam int IDX_XORI  = 14;
    localparam int IDX_SLTI  = 15;
    localparam int IDX_LUI   = 16;
    localparam int IDX_UNI   = 17;
    localparam int IDX_ADD   = 18;
    localparam int IDX_ADDU  = 19;
    localparam int IDX_SUB   = 20;
    localparam int IDX_AND   = 21;
    localparam int IDX_OR    = 22;
    localparam int IDX_XOR   = 23;
    localparam int IDX_NOR   = 24;
    localparam int IDX_SLT   = 25;
    localparam int IDX_SLL   = 26;
    localparam int IDX_SRL   = 27;
    localparam int IDX_SRA   = 28;
    localparam int IDX_JR    = 29;
    localparam int IDX_SYS   = 30;
    localparam int IDX_UNR   = 31;

    // First index that is driven by the decoder rather than a pulse.
    localparam int FIRST_CLASS = IDX_NOP;

    // Major opcode values (bits 31:26).
    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_J     = 6'h02;
    localparam logic [5:0] OP_JAL   = 6'h03;
    localparam logic [5:0] OP_BEQ   = 6'h04;
    localparam logic [5:0] OP_BNE   = 6'h05;
    localparam logic [5:0] OP_ADDI  = 6'h08;
    localparam logic [5:0] OP_SLTI  = 6'h0A;
    localparam logic [5:0] OP_ANDI  = 6'h0C;
    localparam logic [5:0] OP_ORI   = 6'h0D;
    localparam logic [5:0] OP_XORI  = 6'h0E;
    localparam logic [5:0] OP_LUI   = 6'h0F;
    localparam logic [5:0] OP_LW    = 6'h23;
    localparam logic [5:0] OP_SW    = 6'h2B;

    // Function field values (bits 5:0) for register-format words.
    localparam logic [5:0] FN_SLL  = 6'h00;
    localparam logic [5:0] FN_SRL  = 6'h02;
    localparam logic [5:0] FN_SRA  = 6'h03;
    localparam logic [5:0] FN_JR   = 6'h08;
    localparam logic [5:0] FN_SYS  = 6'h0C;
    localparam logic [5:0] FN_ADD  = 6'h20;
    localparam logic [5:0] FN_ADDU = 6'h21;
    localparam logic [5:0] FN_SUB  = 6'h22;
    localparam logic [5:0] FN_AND  = 6'h24;
    localparam logic [5:0] FN_OR   = 6'h25;
    localparam logic [5:0] FN_XOR  = 6'h26;
    localparam logic [5:0] FN_NOR  = 6'h27;
    localparam logic [5:0] FN_SLT  = 6'h2A;

endpackage

// File: rtl/perf_decode.sv
// Module: perf_decode
// Maps a 32-bit instruction word to exactly one class bit in a vector that
// uses the counter numbering of perf_pkg. Bits below FIRST_CLASS are always
// zero. Assumes nothing about retire_vld; gating is done by the caller.
module perf_decode
    import perf_pkg::*;
(
    input  logic [31:0]        word,
    output logic [NUM_CNT-1:0] hit
);

    logic [5:0] opc;
    logic [5:0] fnc;

    assign opc = word[31:26];
    assign fnc = word[5:0];

    // Select one class bit from the opcode, or from the function field.
    always_comb begin
        hit = '0;
        if (word == 32'h0) begin
            hit[IDX_NOP] = 1'b1;
        end else if (opc == OP_RTYPE) begin
            case (fnc)
                FN_ADD:  hit[IDX_ADD]  = 1'b1;
                FN_ADDU: hit[IDX_ADDU] = 1'b1;
                FN_SUB:  hit[IDX_SUB]  = 1'b1;
                FN_AND:  hit[IDX_AND]  = 1'b1;
                FN_OR:   hit[IDX_OR]   = 1'b1;
                FN_XOR:  hit[IDX_XOR]  = 1'b1;
                FN_NOR:  hit[IDX_NOR]  = 1'b1;
                FN_SLT:  hit[IDX_SLT]  = 1'b1;
                FN_SLL:  hit[IDX_SLL]  = 1'b1;
                FN_SRL:  hit[IDX_SRL]  = 1'b1;
                FN_SRA:  hit[IDX_SRA]  = 1'b1;
                FN_JR:   hit[IDX_JR]   = 1'b1;
                FN_SYS:  hit[IDX_SYS]  = 1'b1;
                default: hit[IDX_UNR]  = 1'b1;
            endcase
        end else begin
            case (opc)
                OP_LW:   hit[IDX_LW]   = 1'b1;
                OP_SW:   hit[IDX_SW]   = 1'b1;
                OP_BEQ:  hit[IDX_BEQ]  = 1'b1;
                OP_BNE:  hit[IDX_BNE]  = 1'b1;
                OP_J:    hit[IDX_J]    = 1'b1;
                OP_JAL:  hit[IDX_JAL]  = 1'b1;
                OP_ADDI: hit[IDX_ADDI] = 1'b1;
                OP_ANDI: hit[IDX_ANDI] = 1'b1;
                OP_ORI:  hit[IDX_ORI]  = 1'b1;
                OP_XORI: hit[IDX_XORI] = 1'b1;
                OP_SLTI: hit[IDX_SLTI] = 1'b1;
                OP_LUI:  hit[IDX_LUI]  = 1'b1;
                default: hit[IDX_UNI]  = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/perf_sat_counter.sv
// Module: perf_sat_counter
// One saturating up-counter of width W. It assumes inc is already gated by
// the freeze logic. It holds at all ones instead of wrapping.
module perf_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);

    localparam logic [W-1:0] TOP = '1;

    // Clear on reset, otherwise step by one unless already full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc && (count != TOP)) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/perf_read_mux.sv
// Module: perf_read_mux
// Combinational select of one W-bit slice from a flat vector of N counters.
// It assumes sel is below N. The package gives N as a power of two.
module perf_read_mux #(
    parameter int W = 32,
    parameter int N = 32,
    parameter int S = 5
) (
    input  logic [N*W-1:0] flat,
    input  logic [S-1:0]   sel,
    output logic [W-1:0]   data
);

    // Pick the slice that matches the select.
    always_comb begin
        data = '0;
        for (int k = 0; k < N; k++) begin
            if (sel == S'(k)) begin
                data = flat[k*W +: W];
            end
        end
    end

endmodule

// File: rtl/perf_tally.sv
// Module: perf_tally (top)
// Tallies retirements by class, plus stalls, flushes, cycles and useful
// instructions, in saturating counters that are read through rd_sel.
// A high halt freezes all counts in that cycle and until reset.
// Assumes all inputs are synchronous to clk.
module perf_tally
    import perf_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               retire_vld,
    input  logic [31:0]        retire_word,
    input  logic               stall_pulse,
    input  logic               flush_pulse,
    input  logic               cycle_tick,
    input  logic               halt,
    input  logic [SEL_W-1:0]   rd_sel,
    output logic [CNT_W-1:0]   rd_data
);

    logic                   freeze_q;
    logic                   live;
    logic [NUM_CNT-1:0]     hit_vec;
    logic [NUM_CNT-1:0]     inc_vec;
    logic [NUM_CNT*CNT_W-1:0] cnt_flat;

    // Latch the halt request so the freeze persists until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            freeze_q <= 1'b0;
        end else if (halt) begin
            freeze_q <= 1'b1;
        end
    end

    assign live = !halt && !freeze_q;

    perf_decode u_dec (
        .word (retire_word),
        .hit  (hit_vec)
    );

    // Increment requests for the pulse-driven counters.
    always_comb begin
        inc_vec[IDX_CYC] = live && cycle_tick;
        inc_vec[IDX_USE] = live && retire_vld;
        inc_vec[IDX_STL] = live && stall_pulse;
        inc_vec[IDX_FLS] = live && flush_pulse;
    end

    // Instruction class counters take their increment from the decoder.
    for (genvar g = FIRST_CLASS; g < NUM_CNT; g++) begin : g_cls_inc
        assign inc_vec[g] = live && retire_vld && hit_vec[g];
    end

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        perf_sat_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (inc_vec[g]),
            .count (cnt_flat[g*CNT_W +: CNT_W])
        );
    end

    perf_read_mux #(.W(CNT_W), .N(NUM_CNT), .S(SEL_W)) u_rd (
        .flat (cnt_flat),
        .sel  (rd_sel),
        .data (rd_data)
    );

endmodule

// File: rtl/perf_tally_chk.sv
// Module: perf_tally_chk
// Property checker bound into perf_tally. It watches the decoder output, the
// freeze latch and the flat counter vector.
module perf_tally_chk
    import perf_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     halt,
    input logic                     freeze_q,
    input logic                     retire_vld,
    input logic                     stall_pulse,
    input logic                     cycle_tick,
    input logic [NUM_CNT-1:0]       hit_vec,
    input logic [NUM_CNT*CNT_W-1:0] cnt_flat
);

    localparam logic [CNT_W-1:0] TOP = '1;

    logic [CNT_W-1:0] cyc;
    logic [CNT_W-1:0] useful;

    assign cyc    = cnt_flat[IDX_CYC*CNT_W +: CNT_W];
    assign useful = cnt_flat[IDX_USE*CNT_W +: CNT_W];

    // R1: the first edge after reset sees every counter at zero.
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (cnt_flat == '0));

    // R3: every word falls into exactly one class.
    assert_one_class_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(hit_vec) == 1);

    // R8: a stall without a retire leaves the useful count alone.
    assert_stall_not_useful_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_pulse && !retire_vld) |=> $stable(useful));

    // R9: a live tick below the ceiling advances the cycle count by one.
    assert_cycle_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_tick && !halt && !freeze_q && (cyc != TOP)) |=> (cyc == CNT_W'($past(cyc) + 1'b1)));

    // R10: a full useful counter stays full.
    assert_no_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (useful == TOP) |=> (useful == TOP));

    // R11: nothing moves while halted or after a halt.
    assert_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (halt || freeze_q) |=> $stable(cnt_flat));

endmodule

bind perf_tally perf_tally_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .halt        (halt),
    .freeze_q    (freeze_q),
    .retire_vld  (retire_vld),
    .stall_pulse (stall_pulse),
    .cycle_tick  (cycle_tick),
    .hit_vec     (hit_vec),
    .cnt_flat    (cnt_flat)
);

// File: tb/test_perf_tally.sv
`timescale 1ns/100ps
module test_perf_tally;

    localparam int W    = 8;
    localparam int MAXV = 255;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        retire_vld = 1'b0;
    logic [31:0] retire_word = '0;
    logic        stall_pulse = 1'b0;
    logic        flush_pulse = 1'b0;
    logic        cycle_tick = 1'b0;
    logic        halt = 1'b0;
    logic [4:0]  rd_sel = '0;
    logic [W-1:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;
    int exp_cnt [32];
    bit m_frozen = 1'b0;

    always #5 clk = ~clk;

    perf_tally #(.CNT_W(W)) i_perf_tally (
        .clk (clk), .rst_n (rst_n), .retire_vld (retire_vld),
        .retire_word (retire_word), .stall_pulse (stall_pulse),
        .flush_pulse (flush_pulse), .cycle_tick (cycle_tick),
        .halt (halt), .rd_sel (rd_sel), .rd_data (rd_data)
    );

    // Expected class index of a word (R2..R6 tables).
    function automatic int cls_of(input logic [31:0] w);
        logic [5:0] op = w[31:26];
        logic [5:0] fn = w[5:0];
        if (w == 32'h0) return 4;
        if (op == 6'h00) begin
            case (fn)
                6'h20: return 18; 6'h21: return 19; 6'h22: return 20;
                6'h24: return 21; 6'h25: return 22; 6'h26: return 23;
                6'h27: return 24; 6'h2A: return 25; 6'h00: return 26;
                6'h02: return 27; 6'h03: return 28; 6'h08: return 29;
                6'h0C: return 30; default: return 31;
            endcase
        end
        case (op)
            6'h23: return 5;  6'h2B: return 6;  6'h04: return 7;
            6'h05: return 8;  6'h02: return 9;  6'h03: return 10;
            6'h08: return 11; 6'h0C: return 12; 6'h0D: return 13;
            6'h0E: return 14; 6'h0A: return 15; 6'h0F: return 16;
            default: return 17;
        endcase
    endfunction

    function automatic void bump(input int i);
        if (exp_cnt[i] < MAXV) exp_cnt[i]++;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 32; i++) exp_cnt[i] = 0;
        m_frozen = 1'b0;
    endtask

    // One clock of stimulus; model updated for the edge it lands on.
    task automatic step(input bit v, input logic [31:0] w, input bit st,
                        input bit fl, input bit tk, input bit hl);
        @(negedge clk);
        retire_vld = v; retire_word = w; stall_pulse = st;
        flush_pulse = fl; cycle_tick = tk; halt = hl;
        @(posedge clk);
        if (hl) m_frozen = 1'b1;
        if (!m_frozen) begin
            if (tk) bump(0);
            if (st) bump(2);
            if (fl) bump(3);
            if (v) begin bump(1); bump(cls_of(w)); end
        end
        #1;
        retire_vld = 1'b0; retire_word = '0; stall_pulse = 1'b0;
        flush_pulse = 1'b0; cycle_tick = 1'b0; halt = 1'b0;
    endtask

    task automatic check_one(input int i, input string req);
        rd_sel = 5'(i);
        #1;
        n_chk++;
        if (int'(rd_data) != exp_cnt[i]) begin
            n_bad++;
            $display("FAIL %s sel=%0d actual=%0d expected=%0d", req, i, rd_data, exp_cnt[i]);
        end
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < 32; i++) check_one(i, req);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        check_all("R1 R12 reset state");

        // R2: all-zero word is a useful no-op
        step(1, 32'h0, 0, 0, 1, 0);
        step(1, 32'h0, 0, 0, 1, 0);
        check_all("R2 nop");

        // R3 R4: sweep every function code with opcode 0, nonzero register fields
        for (int f = 0; f < 64; f++)
            step(1, {6'h00, 5'd1, 5'd2, 5'd3, 5'd4, 6'(f)}, 0, 0, 1, 0);
        check_all("R3 R4 funct sweep");

        // R5 R6: sweep every nonzero major opcode
        for (int o = 1; o < 64; o++)
            step(1, {6'(o), 26'h0123456}, 0, 0, 1, 0);
        check_all("R5 R6 opcode sweep");

        // R7 R8: pulses alone, no retire; then all together
        step(0, 32'h2008_0005, 1, 0, 0, 0);
        step(0, 32'h2008_0005, 0, 1, 0, 0);
        step(0, 32'h2008_0005, 1, 1, 1, 0);
        check_all("R7 R8 pulses without retire");
        step(1, 32'h8fad_0000, 1, 1, 1, 0);
        check_all("R8 combined cycle");

        // R9: pipelined accounting identity
        do_reset();
        for (int i = 0; i < 4; i++) step(0, 32'h0, 0, 0, 1, 0);
        for (int i = 0; i < 17; i++) step(1, (i % 3 == 0) ? 32'h0 : 32'h2009_0005, 0, 0, 1, 0);
        for (int i = 0; i < 2; i++) step(0, 32'h0, 1, 0, 1, 0);
        for (int i = 0; i < 3; i++) step(0, 32'h0, 0, 1, 1, 0);
        rd_sel = 5'd0; #1;
        n_chk++;
        if (int'(rd_data) != 17 + 2 + 3 + 4) begin
            n_bad++;
            $display("FAIL R9 cycles actual=%0d expected=%0d", rd_data, 26);
        end
        check_all("R9 pipelined run");

        // R10: saturation with narrow counters
        do_reset();
        for (int i = 0; i < 300; i++) step(1, 32'h0, 0, 0, 1, 0);
        check_one(4, "R10 nop saturated");
        check_one(1, "R10 useful saturated");
        check_one(0, "R10 cycles saturated");
        check_all("R10 saturation");

        // R11: freeze in the halt cycle and after it
        do_reset();
        step(1, 32'h0000_000c, 1, 0, 1, 0);
        step(1, 32'h0c10_0009, 1, 1, 1, 1);
        step(1, 32'h0c10_0009, 1, 1, 1, 0);
        step(1, 32'h03e0_0008, 0, 0, 1, 0);
        check_all("R11 frozen");
        if (exp_cnt[30] != 1 || exp_cnt[10] != 0) begin
            n_bad++;
            $display("FAIL R11 model actual=%0d expected=1", exp_cnt[30]);
        end
        n_chk++;

        do_reset();
        check_all("R1 reset clears after halt");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule